// File: doc/BRIEF.md
# Keyed Refresh Watchdog Timer

This block is a programmable down-counting watchdog. A prescaled tick input steps a counter down once per tick. If the counter runs out while watchdog mode is armed, the block raises a one-cycle internal reset request. Software keeps the system alive by writing a two-byte key to a dedicated refresh register in a fixed order. A completed key makes the counter reload its period on the next tick.

Watchdog mode is armed by clearing a control bit, not by setting it. After reset that bit reads 1, so the counter runs as a plain periodic timer that never asks for a reset. The reset request is an internal signal for the chip's reset logic. It never drives an external reset pin.

Software writes the block through an 8-bit register write port. The port selects one of four addresses:

- address 0: control register. Bit 0 is the disable bit.
- address 1: refresh key register.
- address 2: low byte of the 16-bit reload value.
- address 3: high byte of the 16-bit reload value.

The present count is brought out so the timer can also be used as an ordinary timer.

Top module: `wdog_key_top`

## Requirements
- R1: After reset the disable bit (control address 0, bit 0) is 1, the reload value is 0, the count output reads FFFFh and the reset request is low.
- R2: The count drops by exactly one in the cycle after each clock with tick high. Without a tick it holds its value, whatever is written.
- R3: While the disable bit is 1, a tick at count 1 reloads the counter and no reset request is raised. The disable bit changes only by a write to address 0.
- R4: While the disable bit is 0, a tick at count 1 raises the reset request for one cycle, in the cycle after that clock, and reloads the counter.
- R5: Writing AAh and then 55h to address 1 completes a refresh. At the next tick after the 55h write the counter loads the reload value instead of decrementing.
- R6: Any write to address 1 other than 55h directly after AAh cancels the partial key. This includes a second AAh. A later 55h then has no effect. Writes to other addresses between the two key bytes do not cancel it.
- R7: A reload value of 0 loads FFFFh, the longest period. The count never reads 0.
- R8: When a refresh is pending at the tick where the count is 1, the refresh wins: the counter loads and no reset request is raised.
- R9: Writing the reload bytes (address 2 low, address 3 high) does not change the count until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Register address: 0 control, 1 refresh key, 2 reload low, 3 reload high |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Prescaled tick, one count step per high cycle |
| count_o | output | 16 | Present counter value |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
A fault in the key checker shows up as a count that keeps falling where it should jump back to the reload value. It appears at the first tick after the 55h write, or with a reload where a cancelled key should have had no effect. A wrong disable bit or expiry decision shows on rst_req_o in the cycle right after the expiring tick, together with the reloaded count. A stale or misdecoded reload register shows only at the next load, which can be a whole period later. For that reason the bench keeps periods short and compares the count on every cycle against a cycle-level model.

// File: rtl/wdog_key_pkg.sv
package wdog_key_pkg;
    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdog_key_regs.sv
module wdog_key_regs #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_CTRL = 0,
    parameter int ADDR_RLD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              dis_o,
    output logic [CNT_W-1:0]  reload_o
);
    localparam int NBYTES = CNT_W / DATA_W;

    typedef struct packed {
        logic             dis;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
            regs_d.dis = wr_data[0];
        end
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_en && wr_addr == ADDR_W'(ADDR_RLD + b)) begin
                regs_d.reload[b*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dis    <= 1'b1;
            regs_q.reload <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dis_o    = regs_q.dis;
    assign reload_o = regs_q.reload;

    AST_DIS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(dis_o)); // R3
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_key_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 2,
    parameter int          ADDR_KEY   = 1,
    parameter logic [7:0]  KEY_FIRST  = 8'hAA,
    parameter logic [7:0]  KEY_SECOND = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              refresh_o
);
    typedef struct packed {
        key_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic key_wr;

    assign key_wr = wr_en && (wr_addr == ADDR_W'(ADDR_KEY));

    always_comb begin
        fsm_d     = fsm_q;
        refresh_o = 1'b0;
        if (key_wr) begin
            if (fsm_q.st == KEY_ARMED) begin
                fsm_d.st  = KEY_IDLE;
                refresh_o = (wr_data == DATA_W'(KEY_SECOND));
            end else if (wr_data == DATA_W'(KEY_FIRST)) begin
                fsm_d.st = KEY_ARMED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= KEY_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    AST_KEY_DROPS_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && fsm_q.st == KEY_ARMED) |=> (fsm_q.st == KEY_IDLE)); // R6
    AST_REFRESH_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> (fsm_q.st == KEY_ARMED && key_wr)); // R5
endmodule

// File: rtl/wdog_key_cnt.sv
module wdog_key_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dis,
    input  logic [CNT_W-1:0] reload,
    input  logic             refresh,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_req_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             req;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = (reload == '0) ? '1 : reload;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.req = 1'b0;
        if (tick) begin
            cnt_d.pend = 1'b0;
            if (cnt_q.pend) begin
                cnt_d.cnt = load_val;
            end else if (cnt_q.cnt == ONE) begin
                cnt_d.cnt = load_val;
                cnt_d.req = !dis;
            end else begin
                cnt_d.cnt = cnt_q.cnt - ONE;
            end
        end
        if (refresh) begin
            cnt_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q.cnt  <= '1;
            cnt_q.pend <= 1'b0;
            cnt_q.req  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o   = cnt_q.cnt;
    assign rst_req_o = cnt_q.req;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o)); // R2
    AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !rst_req_o); // R4
    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !rst_req_o); // R3
    AST_PEND_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q.pend) |=> (count_o == $past(load_val) && !rst_req_o)); // R8
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        count_o != '0); // R7
endmodule

// File: rtl/wdog_key_top.sv
module wdog_key_top #(
    parameter int         DATA_W     = 8,
    parameter int         ADDR_W     = 2,
    parameter int         CNT_W      = 16,
    parameter int         ADDR_CTRL  = 0,
    parameter int         ADDR_KEY   = 1,
    parameter int         ADDR_RLD   = 2,
    parameter logic [7:0] KEY_FIRST  = 8'hAA,
    parameter logic [7:0] KEY_SECOND = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [CNT_W-1:0]  count_o,
    output logic              rst_req_o
);
    logic             dis;
    logic [CNT_W-1:0] reload;
    logic             refresh;

    wdog_key_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .ADDR_CTRL(ADDR_CTRL), .ADDR_RLD(ADDR_RLD)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dis_o(dis), .reload_o(reload)
    );

    wdog_key_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_KEY(ADDR_KEY),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .refresh_o(refresh)
    );

    wdog_key_cnt #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dis(dis), .reload(reload),
        .refresh(refresh), .count_o(count_o), .rst_req_o(rst_req_o)
    );

    AST_REQ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !$past(dis)); // R4
endmodule

// File: tb/wdog_key_top_tb_top.sv
`timescale 1ns/1ps
module wdog_key_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic [15:0] count_o;
    logic        rst_req_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side expectations
    bit          m_dis;
    logic [15:0] m_reload, m_cnt;
    bit          m_armed, m_pend, m_req;

    always #2.5 clk = ~clk;

    wdog_key_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .count_o(count_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [15:0] period(input logic [15:0] r);
        return (r == 16'h0) ? 16'hFFFF : r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_dis = 1'b1; m_reload = 16'h0; m_cnt = 16'hFFFF;
        m_armed = 1'b0; m_pend = 1'b0; m_req = 1'b0;
    endtask

    task automatic model_edge(input bit w, input logic [1:0] a,
                              input logic [7:0] d, input bit t);
        logic [15:0] ld;
        bit np;
        ld = period(m_reload);
        np = m_pend;
        m_req = 1'b0;
        if (t) begin
            np = 1'b0;
            if (m_pend) m_cnt = ld;
            else if (m_cnt == 16'd1) begin m_cnt = ld; m_req = !m_dis; end
            else m_cnt = m_cnt - 16'd1;
        end
        if (w) begin
            case (a)
                2'd0: m_dis = d[0];
                2'd2: m_reload[7:0] = d;
                2'd3: m_reload[15:8] = d;
                default: begin
                    if (m_armed) begin
                        m_armed = 1'b0;
                        if (d == 8'h55) np = 1'b1;
                    end else if (d == 8'hAA) m_armed = 1'b1;
                end
            endcase
        end
        m_pend = np;
    endtask

    task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d,
                        input bit t, input string tag);
        wr_en = w; wr_addr = a; wr_data = d; tick = t;
        @(posedge clk);
        model_edge(w, a, d, t);
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(tag, "count", count_o, m_cnt);
        check(tag, "rst_req", {15'h0, rst_req_o}, {15'h0, m_req});
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic tk(input string tag);
        step(1'b0, 2'd0, 8'h0, 1'b1, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "count", count_o, 16'hFFFF);
        check("R1", "rst_req", {15'h0, rst_req_o}, 16'h0);
        step(1'b0, 2'd0, 8'h0, 1'b0, "R2");
        check("R2", "idle hold", count_o, 16'hFFFF);
        // R7 reload zero gives maximum period
        tk("R2"); tk("R2"); tk("R2");
        check("R2", "after 3 ticks", count_o, 16'hFFFC);
        wr(2'd1, 8'hAA, "R5"); wr(2'd1, 8'h55, "R5");
        tk("R7");
        check("R7", "zero reload loads max", count_o, 16'hFFFF);
        // R9 reload write leaves count alone
        wr(2'd2, 8'h05, "R9"); wr(2'd3, 8'h00, "R9");
        check("R9", "count after reload write", count_o, 16'hFFFF);
        tk("R2");
        check("R2", "decrement", count_o, 16'hFFFE);
        // R5 refresh loads period 5
        wr(2'd1, 8'hAA, "R5"); wr(2'd1, 8'h55, "R5");
        check("R5", "no change before tick", count_o, 16'hFFFE);
        tk("R5");
        check("R5", "loaded", count_o, 16'd5);
        // R3 disabled expiry: no request
        for (int i = 0; i < 5; i++) tk("R3");
        check("R3", "reloaded when disabled", count_o, 16'd5);
        check("R3", "no request", {15'h0, rst_req_o}, 16'h0);
        // R4 enabled expiry
        wr(2'd0, 8'h00, "R4");
        for (int i = 0; i < 4; i++) tk("R4");
        check("R4", "count at 1", count_o, 16'd1);
        tk("R4");
        check("R4", "request high", {15'h0, rst_req_o}, 16'h1);
        check("R4", "reloaded", count_o, 16'd5);
        step(1'b0, 2'd0, 8'h0, 1'b0, "R4");
        check("R4", "request one cycle", {15'h0, rst_req_o}, 16'h0);
        // R6 other-address write between keys keeps the key
        tk("R6");
        wr(2'd1, 8'hAA, "R6"); wr(2'd0, 8'h00, "R6"); wr(2'd1, 8'h55, "R6");
        tk("R6");
        check("R6", "key survives other address", count_o, 16'd5);
        // R6 double AA cancels
        tk("R6");
        wr(2'd1, 8'hAA, "R6"); wr(2'd1, 8'hAA, "R6"); wr(2'd1, 8'h55, "R6");
        tk("R6");
        check("R6", "AA AA 55 ignored", count_o, 16'd3);
        wr(2'd1, 8'hAA, "R6"); wr(2'd1, 8'h12, "R6"); wr(2'd1, 8'h55, "R6");
        tk("R6");
        check("R6", "AA 12 55 ignored", count_o, 16'd2);
        // R8 refresh pending at expiry wins
        tk("R8");
        check("R8", "count at 1", count_o, 16'd1);
        wr(2'd1, 8'hAA, "R8"); wr(2'd1, 8'h55, "R8");
        tk("R8");
        check("R8", "loaded", count_o, 16'd5);
        check("R8", "no request", {15'h0, rst_req_o}, 16'h0);
        // constrained random mix
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit w, t;
            logic [1:0] a;
            logic [7:0] d;
            r = $urandom_range(0, 99);
            w = (r < 40);
            t = ($urandom_range(0, 1) == 1);
            a = 2'($urandom_range(0, 3));
            r = $urandom_range(0, 9);
            d = (r < 4) ? 8'hAA : (r < 8) ? 8'h55 : 8'($urandom_range(0, 255));
            if (a == 2'd0) d = {7'h0, ($urandom_range(0, 7) == 0)};
            if (a == 2'd3) d = 8'h00;
            if (a == 2'd2) d = 8'($urandom_range(0, 12));
            step(w, a, d, t, (a == 2'd1) ? "R5" : "R2");
        end
        done = 1'b1;
        finish_run();
    end
endmodule